// File: doc/BRIEF.md
# Half-Buffer Stream Clock Crossing

This block moves an unbroken word stream from a slower write clock into a faster read clock. The write side stores one word into a 16-entry register array on every write-clock edge, stepping its address upward and wrapping at the top. The top address bit marks which half of the array is being filled. That bit is the only signal that crosses into the read domain.

The read side passes that bit through a two-stage synchronizer and watches for any change in it. Each change means one half has just been filled. The reader then drains that half as eight back-to-back words, marking each one with a valid strobe.

The stream interface has no back-pressure in either direction. The write side has no valid and no ready: every write-clock edge after reset carries a word. The read side has a valid strobe and no ready: a consumer must take every word on the cycle it is offered. The read clock must run clearly faster than the write clock, so that a burst ends before the writer finishes the next half.

Top module: `half_xfer_top`

## Requirements
- R1: After either reset, rd_valid and rd_data are 0. No valid word appears until eight words have been written since the write-side reset was released.
- R2: The writer stores wr_data on every wclk rising edge while out of reset, at addresses 0, 1, …, 15, 0, … in that order.
- R3: Every burst holds rd_valid high for exactly 8 consecutive rclk cycles. A low cycle always separates two bursts.
- R4: A burst reads the half the writer has just left. Its first word comes from entry 0 or entry 8, and the address rises by one on each following cycle.
- R5: The words leaving on rd_data while rd_valid is high match the words written, in the same order, with no gap and no repeat.
- R6: The only signal that crosses domains is the half-select bit, through a two-flop synchronizer. A detected change starts the burst on the next rclk edge, so no more than 16 words are ever written but not yet delivered.
- R7: A new half-change never arrives while a burst is draining, provided the read clock runs at least about 1.4 times the write clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_data | input | DW | Stream word, taken on every wclk rising edge |
| rclk | input | 1 | Read-domain clock, faster than wclk |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_data | output | DW | Delivered stream word |
| rd_valid | output | 1 | High for each delivered word, in runs of eight |

## Verification
The bench counts the words written since reset and checks the first valid word against that count. A design that starts draining too early would deliver stale or undefined entries, and this check catches it.

Every valid run is measured. A design that drains seven or nine words, or that lets a new trigger merge two bursts, produces a run length other than eight.

Each delivered word is compared with a queue of the written words. A wrong half base, an address that misses the 15-to-0 wrap, or a missed toggle shows up as a skipped or repeated word.

Both domains are reset in the middle of the stream, part-way through a burst. A reader that keeps any old state after reset would deliver words from before the reset.

// File: rtl/half_xfer_pkg.sv
package half_xfer_pkg;
  typedef enum logic {
    XR_IDLE  = 1'b0,
    XR_DRAIN = 1'b1
  } xr_state_e;
endpackage

// File: rtl/half_buf_wr.sv
module half_buf_wr #(
  parameter int DW          = 16,
  parameter int DEPTH       = 16,
  parameter bit NEG_CAPTURE = 1'b0
) (
  input  logic                     wclk,
  input  logic                     wrst_n,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            rd_word,
  output logic                     half_sel
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] waddr;
  logic [DW-1:0] wdat;
  logic [DW-1:0] mem [DEPTH];

  // optional falling-edge capture for inputs arriving on slow local routing
  generate
    if (NEG_CAPTURE) begin : g_negcap
      logic [DW-1:0] cap_q;
      always_ff @(negedge wclk or negedge wrst_n) begin
        if (!wrst_n) cap_q <= '0;
        else         cap_q <= wr_data;
      end
      assign wdat = cap_q;
    end else begin : g_direct
      assign wdat = wr_data;
    end
  endgenerate

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) waddr <= '0;
    else         waddr <= waddr + 1'b1;
  end

  always_ff @(posedge wclk) begin
    mem[waddr] <= wdat;
  end

  assign rd_word  = mem[rd_addr];
  assign half_sel = waddr[AW-1];

  AST_WADDR_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    $past(wrst_n) |-> waddr == AW'($past(waddr) + 1'b1)); // R2
endmodule

// File: rtl/half_sync.sv
module half_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/half_buf_rd.sv
module half_buf_rd
  import half_xfer_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                     rclk,
  input  logic                     rrst_n,
  input  logic                     half_s,
  input  logic [DW-1:0]            rd_word,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_valid
);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;
  localparam int CW   = AW - 1;

  xr_state_e     state;
  logic          half_prev;
  logic          chg;
  logic          drain;
  logic [AW-1:0] raddr;
  logic [CW-1:0] bcnt;

  assign chg     = half_s ^ half_prev;
  assign drain   = (state == XR_DRAIN);
  assign rd_addr = raddr;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) half_prev <= 1'b0;
    else         half_prev <= half_s;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      state    <= XR_IDLE;
      raddr    <= '0;
      bcnt     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        XR_IDLE: begin
          if (chg) begin
            state <= XR_DRAIN;
            raddr <= {~half_s, {CW{1'b0}}};
            bcnt  <= '0;
          end
        end
        XR_DRAIN: begin
          rd_data  <= rd_word;
          rd_valid <= 1'b1;
          raddr    <= raddr + 1'b1;
          bcnt     <= bcnt + 1'b1;
          if (bcnt == CW'(HALF - 1)) state <= XR_IDLE;
        end
        default: state <= XR_IDLE;
      endcase
    end
  end

  AST_VALID_FROM_DRAIN: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_valid |-> $past(drain)); // R3
  AST_BURST_LEN: assert property (@(posedge rclk) disable iff (!rrst_n)
    $fell(drain) |-> $past(bcnt) == CW'(HALF - 1)); // R3
  AST_ADDR_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
    (drain && $past(drain)) |-> raddr == AW'($past(raddr) + 1'b1)); // R4
  AST_HALF_BASE: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(drain) |-> (raddr[CW-1:0] == '0 && raddr[AW-1] != half_s)); // R4
  AST_START_NEXT: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!drain && chg) |=> drain); // R6
  AST_NO_RETRIGGER: assert property (@(posedge rclk) disable iff (!rrst_n)
    drain |-> !chg); // R7
endmodule

// File: rtl/half_xfer_top.sv
module half_xfer_top #(
  parameter int DW          = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit NEG_CAPTURE = 1'b0
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rclk,
  input  logic          rrst_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_word;
  logic          half_w;
  logic          half_s;

  half_buf_wr #(.DW(DW), .DEPTH(DEPTH), .NEG_CAPTURE(NEG_CAPTURE)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_word(rd_word), .half_sel(half_w)
  );

  half_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(rclk), .rst_n(rrst_n), .d(half_w), .q(half_s)
  );

  half_buf_rd #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .half_s(half_s), .rd_word(rd_word),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/half_xfer_top_test.sv
`timescale 1ns/1ps
module half_xfer_top_test;
  localparam int DW = 16;

  logic          wclk, rclk;
  logic          wrst_n, rrst_n;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int total = 0;
  int bad   = 0;
  int nwr   = 0;
  int nrd   = 0;
  int bursts = 0;
  int run   = 0;
  int last  = 0;
  bit rst_checked = 0;
  bit finished = 0;
  int exp_q[$];

  half_xfer_top #(.DW(DW)) uut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_data(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  initial begin rclk = 1'b0; forever #2.5  rclk = ~rclk; end
  initial begin wclk = 1'b0; forever #3.75 wclk = ~wclk; end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // write-side driver and reference queue; resets both domains twice
  initial begin
    bit wr_live = 0;
    wrst_n = 1'b0;
    rrst_n = 1'b0;
    wr_data = '0;
    for (int wcyc = 0; wcyc < 600; wcyc++) begin
      @(negedge wclk);
      if (wr_live) begin
        exp_q.push_back(int'(wr_data)); // R2: one word per wclk edge
        nwr++;
        wr_data = wr_data + 1'b1;
      end
      wrst_n = !((wcyc < 4) || (wcyc >= 300 && wcyc < 305));
      rrst_n = wrst_n;
      if (!wrst_n) begin
        wr_data = '0;
        exp_q.delete();
        nwr = 0;
      end
      wr_live = wrst_n;
    end
    chk(bursts >= 60, "R3", "burst count", bursts, 60);
    finish_run();
  end

  // read-side monitor, sampled on the falling rclk edge
  initial begin
    forever begin
      @(negedge rclk);
      if (!rrst_n) begin
        if (!rst_checked) begin
          chk(rd_valid == 1'b0, "R1", "valid in reset", int'(rd_valid), 0);
          chk(rd_data == '0, "R1", "data in reset", int'(rd_data), 0);
          rst_checked = 1;
        end
        run = 0;
        nrd = 0;
      end else begin
        rst_checked = 0;
        if (rd_valid) begin
          if (run == 0) begin
            chk(nwr >= 8, "R1", "words written before first valid", nwr, 8);
            chk(rd_data[2:0] == 3'd0, "R4", "burst start offset",
                int'(rd_data[2:0]), 0);
          end else begin
            chk(int'(rd_data) == last + 1, "R4", "ascending in burst",
                int'(rd_data), last + 1);
          end
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5", "valid with nothing pending", int'(rd_data), -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(rd_data) == e, "R5", "stream word (R2 order)",
                int'(rd_data), e);
          end
          last = int'(rd_data);
          run++;
          nrd++;
        end else if (run != 0) begin
          chk(run == 8, "R3", "run length (R7 no merge)", run, 8);
          bursts++;
          run = 0;
        end
        chk(nwr - nrd <= 16, "R6", "undelivered backlog", nwr - nrd, 16);
      end
    end
  end

  initial begin
    #1000000;
    chk(1'b0, "R3", "watchdog expired", 0, 1);
    finish_run();
  end
endmodule